// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block brings a halted core back out of power-down. While the core sleeps, it watches a set of interrupt request pulses and a watchdog wake pulse. A request counts as a wake event only if its flag was clear when power-down began. The flags as they stood at entry arrive already latched on a separate input.

When a wake event is accepted, the block stalls the core for a fixed settle period. At the end of that period it picks one of two exits:

- **Normal interrupt entry.** The block asks for the interrupt vector of the winning source, one gap cycle after the stall drops. It takes this exit only when the winner is an interrupt that is enabled at that moment and the stack has a free level.
- **Resume after the halt.** The block pulses a resume-next strobe in the very first cycle after the stall. It takes this exit in every other case: a watchdog wake, a disabled interrupt, or a full stack.

The surrounding core owns the oscillator, the program counter, the stack and any pending interrupt state. It lowers its sleep indication once it sees either exit strobe.

Top module: `wake_seq`

## Requirements
- R1: During and right after reset, `stall`, `resumeNext` and `vectorReq` are all low.
- R2: With `sleeping` low, interrupt pulses and watchdog pulses start no wake sequence: `stall` stays low.
- R3: A wake event is sampled on a clock edge. `stall` goes high from that edge and stays high for exactly SETTLE_CYCLES (default 512) cycles, whatever the source.
- R4: An interrupt source whose bit in `irqFlagAtEntry` is 1 cannot wake the core. Its pulses are ignored while that bit is set.
- R5: If the winner is an interrupt source and, on the edge where the delay ends, its `irqEnable` bit is 1 and `stackFull` is 0, then:
  - no strobe fires in the first cycle after `stall` falls;
  - in the second cycle, `vectorReq` pulses for one cycle;
  - during that pulse, `vectorIdx` carries the winner's index.
- R6: If the winning interrupt's `irqEnable` bit is 0 when the delay ends, `resumeNext` pulses for one cycle in the first cycle after `stall` falls, and `vectorReq` stays low.
- R7: If `stackFull` is 1 when the delay ends, the exit is `resumeNext` as in R6, even for an enabled interrupt.
- R8: When several qualifying sources fire in the same cycle, the lowest interrupt index wins. Any qualifying interrupt beats the watchdog.
- R9: Wake events that arrive while a settle delay is running are ignored. They neither restart nor lengthen the delay, and they do not change the winner.
- R10: A watchdog wake pulse while sleeping always exits through `resumeNext` after the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleeping | input | 1 | Core is in power-down |
| irqPulse | input | NUM_SRC | Per-source interrupt request pulses |
| irqFlagAtEntry | input | NUM_SRC | Request flags as latched at power-down entry |
| irqEnable | input | NUM_SRC | Per-source interrupt enable bits |
| stackFull | input | 1 | No free stack level |
| wdtWake | input | 1 | Watchdog wake pulse |
| stall | output | 1 | Holds the core during the settle delay |
| resumeNext | output | 1 | One-cycle strobe: continue after the halt |
| vectorReq | output | 1 | One-cycle strobe: start interrupt entry |
| vectorIdx | output | $clog2(NUM_SRC) | Index of the source being vectored |

## Verification
The assertions assume that `sleeping` drops no later than the cycle after an exit strobe, so a stale sleep flag never re-arms a wake. They also assume that `irqFlagAtEntry`, `irqEnable` and `stackFull` are steady around the edge where the delay ends. The directed stimulus honours both assumptions. It raises `sleeping` before each pulse, lowers it on the cycle it observes `resumeNext` or `vectorReq`, and changes the enable, flag and stack inputs only while the block is idle. Late wake pulses are injected only in the middle of a running delay.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RESUME,
    ST_GAP,
    ST_VECTOR
  } wakeState_e;

  typedef struct packed {
    logic loadCnt;
    logic latchSrc;
  } ctrlStrobes_t;

endpackage

// File: rtl/wake_seq_dpath.sv
module wake_seq_dpath
  import wake_seq_pkg::*;
#(
  parameter int NUM_SRC       = 4,
  parameter int SETTLE_CYCLES = 512,
  localparam int IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W        = $clog2(SETTLE_CYCLES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleeping,
  input  logic [NUM_SRC-1:0] irqPulse,
  input  logic [NUM_SRC-1:0] irqFlagAtEntry,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               stackFull,
  input  logic               wdtWake,
  input  ctrlStrobes_t       strobes,
  output logic               wakeEvent,
  output logic               cntDone,
  output logic               takeVector,
  output logic [IDX_W-1:0]   winIdx
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic [NUM_SRC-1:0] qualMask;
  logic               anyQual;
  logic [IDX_W-1:0]   firstIdx;
  logic [CNT_W-1:0]   cnt;
  logic               winIsIrq;

  assign qualMask  = irqPulse & ~irqFlagAtEntry;
  assign anyQual   = |qualMask;
  assign wakeEvent = sleeping & (anyQual | wdtWake);

  // Fixed priority: lowest index wins, scanned from the top down.
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qualMask[i]) firstIdx = IDX_W'(i);
    end
  end

  // Settle counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.loadCnt) begin
      cnt <= LOAD_VAL;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntDone = (cnt == '0);

  // Winner capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winIdx   <= '0;
      winIsIrq <= 1'b0;
    end else if (strobes.latchSrc) begin
      winIdx   <= firstIdx;
      winIsIrq <= anyQual;
    end
  end

  assign takeVector = winIsIrq & irqEnable[winIdx] & ~stackFull;

endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
  import wake_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wakeEvent,
  input  logic         cntDone,
  input  logic         takeVector,
  output ctrlStrobes_t strobes,
  output logic         stall,
  output logic         resumeNext,
  output logic         vectorReq
);

  wakeState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobes.loadCnt  = 1'b0;
    strobes.latchSrc = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (wakeEvent) begin
          strobes.loadCnt  = 1'b1;
          strobes.latchSrc = 1'b1;
          stateNext        = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (cntDone) stateNext = takeVector ? ST_GAP : ST_RESUME;
      end
      ST_RESUME: stateNext = ST_IDLE;
      ST_GAP:    stateNext = ST_VECTOR;
      ST_VECTOR: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign stall      = (state == ST_SETTLE);
  assign resumeNext = (state == ST_RESUME);
  assign vectorReq  = (state == ST_VECTOR);

endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int NUM_SRC       = 4,
  parameter int SETTLE_CYCLES = 512,
  localparam int IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleeping,
  input  logic [NUM_SRC-1:0] irqPulse,
  input  logic [NUM_SRC-1:0] irqFlagAtEntry,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               stackFull,
  input  logic               wdtWake,
  output logic               stall,
  output logic               resumeNext,
  output logic               vectorReq,
  output logic [IDX_W-1:0]   vectorIdx
);

  ctrlStrobes_t strobes;
  logic         wakeEvent;
  logic         cntDone;
  logic         takeVector;

  wake_seq_dpath #(
    .NUM_SRC      (NUM_SRC),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .sleeping      (sleeping),
    .irqPulse      (irqPulse),
    .irqFlagAtEntry(irqFlagAtEntry),
    .irqEnable     (irqEnable),
    .stackFull     (stackFull),
    .wdtWake       (wdtWake),
    .strobes       (strobes),
    .wakeEvent     (wakeEvent),
    .cntDone       (cntDone),
    .takeVector    (takeVector),
    .winIdx        (vectorIdx)
  );

  wake_seq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wakeEvent (wakeEvent),
    .cntDone   (cntDone),
    .takeVector(takeVector),
    .strobes   (strobes),
    .stall     (stall),
    .resumeNext(resumeNext),
    .vectorReq (vectorReq)
  );

endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int NUM_SRC       = 4,
  parameter int SETTLE_CYCLES = 512,
  localparam int IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int RUN_W        = $clog2(SETTLE_CYCLES) + 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               sleeping,
  input logic [NUM_SRC-1:0] irqPulse,
  input logic [NUM_SRC-1:0] irqFlagAtEntry,
  input logic               wdtWake,
  input logic               stall,
  input logic               resumeNext,
  input logic               vectorReq,
  input logic [IDX_W-1:0]   vectorIdx
);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      runLen <= '0;
    else if (stall) runLen <= runLen + 1'b1;
    else            runLen <= '0;
  end

  // R1
  exclusive_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stall, resumeNext, vectorReq}));

  // R3
  settle_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> (runLen == RUN_W'(SETTLE_CYCLES)));

  // R2
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(sleeping && (wdtWake || |(irqPulse & ~irqFlagAtEntry))));

  // R5
  gap_then_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stall) && !resumeNext) |=> vectorReq);

  // R6
  resume_right_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeNext |-> $past(stall));

  // R5
  vector_idx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    vectorReq |-> ($stable(vectorIdx) && !$past(stall)));

endmodule

bind wake_seq wake_seq_chk #(
  .NUM_SRC      (NUM_SRC),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .sleeping      (sleeping),
  .irqPulse      (irqPulse),
  .irqFlagAtEntry(irqFlagAtEntry),
  .wdtWake       (wdtWake),
  .stall         (stall),
  .resumeNext    (resumeNext),
  .vectorReq     (vectorReq),
  .vectorIdx     (vectorIdx)
);

// File: tb/wake_seq_tb.sv
module wake_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 4;
  localparam int SETTLE     = 512;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            sleeping = 1'b0;
  logic [NSRC-1:0] irqPulse = '0;
  logic [NSRC-1:0] irqFlagAtEntry = '0;
  logic [NSRC-1:0] irqEnable = '0;
  logic            stackFull = 1'b0;
  logic            wdtWake = 1'b0;
  logic            stall, resumeNext, vectorReq;
  logic [1:0]      vectorIdx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wake_seq #(.NUM_SRC(NSRC), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .sleeping(sleeping), .irqPulse(irqPulse),
    .irqFlagAtEntry(irqFlagAtEntry), .irqEnable(irqEnable),
    .stackFull(stackFull), .wdtWake(wdtWake), .stall(stall),
    .resumeNext(resumeNext), .vectorReq(vectorReq), .vectorIdx(vectorIdx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives a one-cycle pulse at a negedge so it is sampled on the next posedge.
  task automatic pulse(input logic [NSRC-1:0] irqs, input logic wdt);
    irqPulse = irqs;
    wdtWake  = wdt;
    @(negedge clk);
    irqPulse = '0;
    wdtWake  = 1'b0;
  endtask

  // After a pulse: counts stall cycles, then checks the exit path.
  task automatic expectWake(input bit expVec, input int expIdx, input string tag,
                            input bool_inject = 1'b0, input logic [NSRC-1:0] lateIrq = '0);
    int n = 0;
    while (stall && n < 2 * SETTLE) begin
      if (bool_inject && n == SETTLE / 2) pulse(lateIrq, 1'b1);
      else @(negedge clk);
      n++;
    end
    chk(n == SETTLE, {tag, " R3 stall length"}, n, SETTLE);
    if (expVec) begin
      chk(!resumeNext && !vectorReq, {tag, " R5 gap cycle"}, {resumeNext, vectorReq}, 0);
      @(negedge clk);
      chk(vectorReq == 1'b1, {tag, " R5 vectorReq"}, vectorReq, 1);
      chk(vectorIdx == 2'(expIdx), {tag, " R5 vectorIdx"}, vectorIdx, expIdx);
      sleeping = 1'b0;
    end else begin
      chk(resumeNext && !vectorReq, {tag, " R6 resumeNext"}, {resumeNext, vectorReq}, 2);
      sleeping = 1'b0;
      @(negedge clk);
      chk(!vectorReq && !resumeNext, {tag, " R6 no later strobe"}, {resumeNext, vectorReq}, 0);
    end
    repeat (3) @(negedge clk);
    chk(!stall, {tag, " R9 no restart"}, stall, 0);
  endtask

  task automatic testReset();
    chk(!stall && !resumeNext && !vectorReq, "R1 reset outputs",
        {stall, resumeNext, vectorReq}, 0);
  endtask

  task automatic testAwakeIgnored();
    sleeping = 1'b0;
    irqEnable = '1;
    pulse(4'b0101, 1'b1);
    repeat (4) begin
      chk(!stall && !resumeNext && !vectorReq, "R2 awake ignores events", stall, 0);
      @(negedge clk);
    end
  endtask

  task automatic testWdt();
    sleeping = 1'b1;
    pulse('0, 1'b1);
    chk(stall == 1'b1, "R3 stall rises after wdt", stall, 1);
    expectWake(1'b0, 0, "R10 wdt");
  endtask

  task automatic testIrqEnabled();
    irqEnable = 4'b0100; stackFull = 1'b0; sleeping = 1'b1;
    pulse(4'b0100, 1'b0);
    expectWake(1'b1, 2, "R5 irq2 enabled");
  endtask

  task automatic testIrqDisabled();
    irqEnable = 4'b1011; sleeping = 1'b1;
    pulse(4'b0100, 1'b0);
    expectWake(1'b0, 0, "R6 irq2 disabled");
  endtask

  task automatic testStackFull();
    irqEnable = '1; stackFull = 1'b1; sleeping = 1'b1;
    pulse(4'b0010, 1'b0);
    expectWake(1'b0, 0, "R7 stack full");
    stackFull = 1'b0;
  endtask

  task automatic testPreFlag();
    irqEnable = '1; irqFlagAtEntry = 4'b1000; sleeping = 1'b1;
    pulse(4'b1000, 1'b0);
    repeat (3) begin
      chk(!stall, "R4 pre-set flag blocks wake", stall, 0);
      @(negedge clk);
    end
    pulse(4'b1001, 1'b0);
    expectWake(1'b1, 0, "R4 other source wakes");
    irqFlagAtEntry = '0;
  endtask

  task automatic testPriority();
    irqEnable = '1; sleeping = 1'b1;
    pulse(4'b1010, 1'b1);
    expectWake(1'b1, 1, "R8 lowest index and over wdt");
  endtask

  task automatic testLateIgnored();
    irqEnable = '1; sleeping = 1'b1;
    pulse('0, 1'b1);
    expectWake(1'b0, 0, "R9 late events", 1'b1, 4'b0001);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAwakeIgnored();
    testWdt();
    testIrqEnabled();
    testIrqDisabled();
    testStackFull();
    testPreFlag();
    testPriority();
    testLateIgnored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule